// File: doc/BRIEF.md
# Oversampled Video Line Capture

This block takes a two-line digital video source (one intensity bit on each line, so four grey levels per pixel) and turns it into byte writes for a frame buffer. It runs from a sample clock four times the source pixel rate. Each video line is sampled on both edges of that clock. The two sample streams are merged with an AND or an OR, chosen by an input. Every four merged samples of a pixel are then reduced to one bit by a voter whose borderline decisions are programmable.

A line starts at the falling edge of horizontal sync. From then on a sample counter walks through the line. Every sixteen sample clocks the block packs four pixels (two bits each) into one byte and writes it. The write address is formed from the line number and the byte column. Vertical sync restarts the line numbering. Writes stop for lines past the buffer height, for samples past the line width, and whenever the write-permit input is low. The memory itself, the clocking and the display side are outside the block.

Top module: `vid_line_capture`

## Requirements
- R1: While `rst_n` is low, `mem_we_o` is 0 and both `mem_addr_o` and `mem_data_o` are all zeros.
- R2: Each video line is captured on rising and on falling clock edges. With `merge_or_i` = 1 a merged sample is the OR of the two captures taken in the same clock period; with `merge_or_i` = 0 it is their AND.
- R3: The voter reads a pixel's four merged samples as a 4-bit pattern whose MSB is the earliest sample. Pattern 1111 votes 1. The patterns 1110, 0111, 1100, 0110 and 0011 vote `vote_cfg_i[4]`, `[3]`, `[2]`, `[1]` and `[0]` respectively. Every other pattern votes 0.
- R4: In each byte, pixel 0 (the earliest) sits at bits 5:4, pixel 1 at 7:6, pixel 2 at 1:0 and pixel 3 at 3:2. In each pair the upper bit is the `vid_hi_i` vote and the lower bit is the `vid_lo_i` vote.
- R5: Both sync inputs pass through a two-flop synchroniser. Count as edge 1 the first rising clock edge that sees `hsync_i` low after it was high. Byte column c then covers the sixteen rising edges 3+16c to 18+16c, each together with the falling edge that follows it. The byte's address is {line number, c}, with the line number in the upper bits.
- R6: A write pulse is 13 clock cycles long. It rises two cycles after the byte is latched. Address and data hold steady for the whole pulse.
- R7: A write pulse starts only if `wr_permit_i` was high at the clock edge that would raise it.
- R8: The line number is held at 0 while vertical sync is high and advances at each line start. Lines numbered ROWS or higher never write.
- R9: After reset and before the first line start, nothing is written. Samples past PIXELS pixels of a line are never written. Each line therefore writes at most PIXELS/4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync; its falling edge starts a line |
| vsync_i | input | 1 | Vertical sync; high clears the line number |
| vid_hi_i | input | 1 | Video intensity, upper bit |
| vid_lo_i | input | 1 | Video intensity, lower bit |
| merge_or_i | input | 1 | 1: OR the two edge captures, 0: AND them |
| vote_cfg_i | input | 5 | Votes for the five borderline patterns |
| wr_permit_i | input | 1 | Permits writes when high |
| mem_addr_o | output | log2(ROWS)+log2(PIXELS/4) | Write address {line, column} |
| mem_data_o | output | 8 | Packed four-pixel byte |
| mem_we_o | output | 1 | Write enable |

## Verification
The bench builds the block with PIXELS = 32 and ROWS = 4. A full line is then eight bytes and a frame needs only six lines. This makes it cheap to cover the counter wrap at the end of a line, the blocked lines past the buffer height and several complete frames. The same logic scales to 512 by 256. Every pixel draws a pattern from the voter's special set. One edge capture is set to that pattern and the other is noised so that only the selected merge gives the pattern back, which makes a wrong merge, vote or bit position show up as a data miscompare.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  // samples per pixel on each clock edge
  localparam int unsigned OVS          = 4;
  // pixels packed into one memory byte
  localparam int unsigned PIX_PER_BYTE = 4;
  // sample clocks per byte
  localparam int unsigned GRP_W        = OVS * PIX_PER_BYTE;
  // configurable borderline patterns in the voter
  localparam int unsigned CFG_W        = 5;
endpackage

// File: rtl/vlc_sync.sv
module vlc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o
);
  logic meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign level_o = stab_q;
endmodule

// File: rtl/vlc_oversample.sv
module vlc_oversample #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vid_i,
  input  logic         or_mode_i,
  output logic [W-1:0] merged_o
);
  logic [W-1:0] pos_q, neg_q;

  // capture on the rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= {pos_q[W-2:0], vid_i};
  end

  // capture on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= '0;
    else        neg_q <= {neg_q[W-2:0], vid_i};
  end

  assign merged_o = or_mode_i ? (pos_q | neg_q) : (pos_q & neg_q);
endmodule

// File: rtl/vlc_voter.sv
module vlc_voter (
  input  logic [3:0] pat_i,
  input  logic [4:0] cfg_i,
  output logic       vote_o
);
  always_comb begin
    case (pat_i)
      4'b1111: vote_o = 1'b1;
      4'b1110: vote_o = cfg_i[4];
      4'b0111: vote_o = cfg_i[3];
      4'b1100: vote_o = cfg_i[2];
      4'b0110: vote_o = cfg_i[1];
      4'b0011: vote_o = cfg_i[0];
      default: vote_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/vid_line_capture.sv
module vid_line_capture
  import vlc_pkg::*;
#(
  parameter int unsigned PIXELS = 512,
  parameter int unsigned ROWS   = 256,
  localparam int unsigned H_W   = $clog2(PIXELS * OVS),
  localparam int unsigned COL_W = H_W - $clog2(GRP_W),
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned AW    = ROW_W + COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             vid_hi_i,
  input  logic             vid_lo_i,
  input  logic             merge_or_i,
  input  logic [CFG_W-1:0] vote_cfg_i,
  input  logic             wr_permit_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic [7:0]       mem_data_o,
  output logic             mem_we_o
);
  // ---------------- sync inputs ----------------
  logic hs_lvl, vs_lvl, hs_prev_q, hs_fall;

  vlc_sync u_hs (.clk(clk), .rst_n(rst_n), .async_i(hsync_i), .level_o(hs_lvl));
  vlc_sync u_vs (.clk(clk), .rst_n(rst_n), .async_i(vsync_i), .level_o(vs_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_prev_q <= 1'b0;
    else        hs_prev_q <= hs_lvl;
  end
  assign hs_fall = hs_prev_q & ~hs_lvl;

  // ---------------- sampling, voting, packing ----------------
  logic [1:0]       vid_w;
  logic [GRP_W-1:0] mrg [2];
  logic [7:0]       byte_w;

  assign vid_w = {vid_hi_i, vid_lo_i};

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    vlc_oversample #(.W(GRP_W)) u_os (
      .clk      (clk),
      .rst_n    (rst_n),
      .vid_i    (vid_w[ch]),
      .or_mode_i(merge_or_i),
      .merged_o (mrg[ch])
    );
    for (genvar p = 0; p < PIX_PER_BYTE; p++) begin : g_px
      localparam int unsigned LSB = ((p + 2) % 4) * 2;
      vlc_voter u_vote (
        .pat_i (mrg[ch][GRP_W-1-OVS*p -: OVS]),
        .cfg_i (vote_cfg_i),
        .vote_o(byte_w[LSB+ch])
      );
    end
  end

  // ---------------- line sequencing ----------------
  logic [H_W-1:0]   h_q, h_d;
  logic             done_q, done_d;
  logic [ROW_W:0]   line_q, line_d;
  logic [ROW_W:0]   row_q, row_d;
  logic             vld_q, vld_d;
  logic             we_q, we_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [7:0]       data_q, data_d;
  logic [3:0]       nib;

  assign nib = h_q[3:0];

  always_comb begin
    h_d    = h_q + 1'b1;
    done_d = done_q;
    line_d = line_q;
    row_d  = row_q;
    vld_d  = vld_q;
    we_d   = we_q;
    addr_d = addr_q;
    data_d = data_q;
    if (&h_q) done_d = 1'b1;
    if (nib == 4'hF) begin
      data_d = byte_w;
      addr_d = {row_q[ROW_W-1:0], h_q[H_W-1:4]};
      vld_d  = ~done_q & ~row_q[ROW_W];
    end
    if (nib == 4'h1) we_d = vld_q & wr_permit_i;
    if (nib == 4'hE) we_d = 1'b0;
    if (vs_lvl) line_d = '0;
    if (hs_fall) begin
      h_d    = '0;
      done_d = 1'b0;
      vld_d  = 1'b0;
      we_d   = 1'b0;
      row_d  = line_q;
      if (!vs_lvl && !line_q[ROW_W]) line_d = line_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      done_q <= 1'b1;
      line_q <= '0;
      row_q  <= '0;
      vld_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      h_q    <= h_d;
      done_q <= done_d;
      line_q <= line_d;
      row_q  <= row_d;
      vld_q  <= vld_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_data_o = data_q;
  assign mem_we_o   = we_q;
endmodule

// File: rtl/vlc_capture_chk.sv
module vlc_capture_chk #(
  parameter int unsigned AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [7:0]    mem_data_o,
  input logic          wr_permit_i,
  input logic          hs_fall,
  input logic          row_blk
);
  logic       seen_q;
  logic [4:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      seen_q <= seen_q | hs_fall;
      run_q  <= mem_we_o ? ((&run_q) ? run_q : run_q + 1'b1) : '0;
    end
  end

  assert_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (!mem_we_o || ($stable(mem_addr_o) && $stable(mem_data_o))));

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 5'd13);

  assert_permit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> $past(wr_permit_i));

  assert_row_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !row_blk);

  assert_no_early_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> seen_q);
endmodule

bind vid_line_capture vlc_capture_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o),
  .wr_permit_i(wr_permit_i),
  .hs_fall    (hs_fall),
  .row_blk    (row_q[ROW_W])
);

// File: tb/vid_line_capture_tb.sv
module vid_line_capture_tb;
  localparam int CLK_PERIOD = 8;
  localparam int PIXELS = 32;
  localparam int ROWS   = 4;
  localparam int NB     = PIXELS / 4;
  localparam int COL_W  = $clog2(NB);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int AW     = ROW_W + COL_W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hsync, vsync, vid_hi, vid_lo, merge_or, wr_permit;
  logic [4:0]    vote_cfg;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data;
  logic          mem_we;

  int n_chk = 0;
  int n_bad = 0;
  int n_got = 0;
  int n_exp = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [AW+7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_line_capture #(.PIXELS(PIXELS), .ROWS(ROWS)) u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .vid_hi_i(vid_hi), .vid_lo_i(vid_lo), .merge_or_i(merge_or),
    .vote_cfg_i(vote_cfg), .wr_permit_i(wr_permit),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_we_o(mem_we)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [3:0] rnd4();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[3:0];
  endfunction

  function automatic logic [3:0] pick_pat(input logic [2:0] k);
    case (k)
      3'd0: return 4'b1111;
      3'd1: return 4'b1110;
      3'd2: return 4'b0111;
      3'd3: return 4'b1100;
      3'd4: return 4'b0110;
      3'd5: return 4'b0011;
      3'd6: return 4'b0000;
      default: return 4'b1010;
    endcase
  endfunction

  // R3 reference vote
  function automatic logic vote_ref(input logic [3:0] pat, input logic [4:0] cfg);
    if (pat == 4'b1111) return 1'b1;
    if (pat == 4'b1110) return cfg[4];
    if (pat == 4'b0111) return cfg[3];
    if (pat == 4'b1100) return cfg[2];
    if (pat == 4'b0110) return cfg[1];
    if (pat == 4'b0011) return cfg[0];
    return 1'b0;
  endfunction

  // one sample-clock slot: r seen by next rising edge, f by the falling edge after it
  task automatic slot(input logic hs, input logic vs, input logic [1:0] r, input logic [1:0] f);
    @(negedge clk); #(CLK_PERIOD/4);
    hsync = hs; vsync = vs; vid_hi = r[1]; vid_lo = r[0];
    @(posedge clk); #(CLK_PERIOD/4);
    vid_hi = f[1]; vid_lo = f[0];
  endtask

  // driver: one line, pushes expected writes
  task automatic run_line(input int row, input logic or_m, input logic [4:0] cfg, input logic permit);
    merge_or = or_m; vote_cfg = cfg; wr_permit = permit;
    slot(1'b0, 1'b0, 2'b00, 2'b00);
    slot(1'b0, 1'b0, 2'b00, 2'b00);
    for (int c = 0; c < NB; c++) begin
      logic [7:0] eb = '0;
      for (int p = 0; p < 4; p++) begin
        logic [3:0] rh, fh, rl, fl, ph, pl, nz, mh, ml;
        int lsb = ((p + 2) % 4) * 2;
        ph = pick_pat(rnd4()[2:0]);
        pl = pick_pat(rnd4()[2:0]);
        nz = rnd4();
        rh = ph; fh = or_m ? (ph & nz) : (ph | nz);
        nz = rnd4();
        rl = pl; fl = or_m ? (pl & nz) : (pl | nz);
        if (lfsr[5]) begin logic [3:0] t = rh; rh = fh; fh = t; end
        mh = or_m ? (rh | fh) : (rh & fh);          // R2 merge
        ml = or_m ? (rl | fl) : (rl & fl);
        for (int k = 3; k >= 0; k--)
          slot(1'b0, 1'b0, {rh[k], rl[k]}, {fh[k], fl[k]});
        eb[lsb+1] = vote_ref(mh, cfg);              // R4 packing
        eb[lsb]   = vote_ref(ml, cfg);
      end
      if (permit && row < ROWS) begin
        logic [ROW_W-1:0] rw = ROW_W'(row);
        logic [COL_W-1:0] cw = COL_W'(c);
        exp_q.push_back({rw, cw, eb});
        n_exp++;
      end
    end
    for (int i = 0; i < 30; i++) slot(1'b0, 1'b0, rnd4()[1:0], rnd4()[1:0]);
    for (int i = 0; i < 4; i++)  slot(1'b1, 1'b0, 2'b00, 2'b00);
  endtask

  task automatic run_frame(input logic or_m, input int off_line);
    for (int i = 0; i < 4; i++) slot(1'b1, 1'b1, 2'b00, 2'b00);
    for (int i = 0; i < 4; i++) slot(1'b1, 1'b0, 2'b00, 2'b00);
    for (int ln = 0; ln < ROWS + 2; ln++) begin
      logic [4:0] cfg;
      cfg = (ln == 0) ? 5'h1F : (ln == 1) ? 5'h00 : {rnd4()[0], rnd4()};
      run_line(ln, or_m, cfg, ln != off_line);
    end
  endtask

  // monitor: pops expected writes at each write pulse
  initial begin
    logic prev_we = 1'b0;
    int run = 0;
    logic [AW+7:0] held = '0;
    logic [AW+7:0] e;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_we = 1'b0;
      end else begin
        if (mem_we && !prev_we) begin
          n_got++;
          held = {mem_addr, mem_data};
          run = 1;
          if (exp_q.size() == 0) begin
            check("R7 R8 R9 unexpected write", 32'd1, 32'd0);
          end else begin
            e = exp_q.pop_front();
            check("R5 address", 32'(mem_addr), 32'(e[AW+7:8]));
            check("R2 R3 R4 data", 32'(mem_data), 32'(e[7:0]));
          end
        end else if (mem_we) begin
          run++;
          check("R6 hold", 32'({mem_addr, mem_data}), 32'(held));
        end else if (prev_we) begin
          check("R6 pulse width", 32'(run), 32'd13);
        end
        prev_we = mem_we;
      end
    end
  end

  initial begin
    rst_n = 1'b0; hsync = 1'b1; vsync = 1'b0; vid_hi = 1'b0; vid_lo = 1'b0;
    merge_or = 1'b1; vote_cfg = 5'h00; wr_permit = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 we in reset", 32'(mem_we), 32'd0);
    check("R1 addr in reset", 32'(mem_addr), 32'd0);
    check("R1 data in reset", 32'(mem_data), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R9: no line start yet, random video must not write
    for (int i = 0; i < 100; i++) slot(1'b1, 1'b0, rnd4()[1:0], rnd4()[1:0]);
    check("R9 no write before first line", 32'(n_got), 32'd0);
    run_frame(1'b1, -1);
    run_frame(1'b0, -1);
    run_frame(1'b1, 1);      // R7: line 1 without permit
    run_frame(1'b0, 2);
    for (int i = 0; i < 40; i++) slot(1'b1, 1'b0, 2'b00, 2'b00);
    check("R7 R8 pending expected writes", 32'(exp_q.size()), 32'd0);
    check("R8 R9 write count", 32'(n_got), 32'(n_exp));
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule